// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block collects every interrupt cause of a multi-stream audio controller into one global status word and drives a single level-sensitive interrupt line towards the host. The causes are the response-ring status bits qualified by their ring enables, the codec state-change flags with their wake-enable mask, and, for every stream, a three-bit status field qualified by the matching bits of that stream's control field.

Each clock the block recomputes the status word from its inputs and registers it together with the interrupt line. The top bit of the word reports "something is pending" and is informational only. The line is raised only when the master enable in the interrupt control word is set and a pending controller or stream bit also has its own enable bit set. The logic that sets and clears the individual source bits lives outside this block, and so does the register decode.

Top module: `aud_irq_aggr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `int_sts` and `irq` are both cleared to 0 at that edge.
- R2: Status bit 30 (controller cause) is set when `ring_sts & ring_ctl` is non-zero. Ring bit 0 is the response-interrupt flag and its enable. Ring bit 1 is the overrun flag and its enable. A ring flag whose enable is clear does not set bit 30.
- R3: Status bit 30 is set when any bit of `codec_sts` is set, whatever the value of `wake_en`.
- R4: Status bit n (n below `NUM_STREAMS`) is set when `strm_sts[n] & strm_ctl[n]` is non-zero. Field bit 0 is completion, bit 1 is FIFO error and bit 2 is descriptor error. A status bit without its matching control bit does not set bit n.
- R5: Status bit 31 is set exactly when any other status bit is set. Bits `NUM_STREAMS` to 29 always read 0.
- R6: `irq` is 1 exactly when `int_ctl[31]` is set and at least one of these holds: status bit 30 and `int_ctl[30]` are both set, or some stream status bit n and `int_ctl[n]` are both set.
- R7: Status bit 31 never raises `irq` by itself. With only `int_ctl[31]` set, `irq` stays 0 while status bits are set.
- R8: `int_sts` and `irq` change only at a rising edge, and they reflect the inputs sampled at that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_sts | input | 2 | Response-ring flags (bit 0 response, bit 1 overrun) |
| ring_ctl | input | 2 | Response-ring interrupt enables, same positions |
| codec_sts | input | NUM_CODECS | Codec state-change flags |
| wake_en | input | NUM_CODECS | Wake-enable mask for the codec flags |
| strm_sts | input | NUM_STREAMS x 3 | Per-stream status (bit 0 completion, 1 FIFO error, 2 descriptor error) |
| strm_ctl | input | NUM_STREAMS x 3 | Per-stream interrupt enables, same positions |
| int_ctl | input | 32 | Interrupt control: bit 31 master, bit 30 controller, bit n stream n |
| int_sts | output | 32 | Registered interrupt status word |
| irq | output | 1 | Registered interrupt line level |

## Verification
The assertions take for granted that the inputs are stable around the rising edge and free of X once reset is released. They check registered values against the inputs of the previous cycle, and they are gated on reset having been released in that previous cycle, so the clearing edge of reset is never compared with live inputs. The bench drives every input on the falling edge and samples one time unit after the rising edge. Each scenario also holds its inputs across a rising edge so that the one-cycle latency and the masking cases can be observed at the ports.

// File: rtl/aud_irq_pkg.sv
// Package: shared field positions for the interrupt aggregator.
// Assumes per-stream status and control fields share one bit layout.
package aud_irq_pkg;
    localparam int SRC_IOC  = 0;   // completion
    localparam int SRC_FIFO = 1;   // FIFO error
    localparam int SRC_DESC = 2;   // descriptor error
    localparam int SRC_W    = 3;

    localparam int RING_RESP = 0;  // response interrupt
    localparam int RING_OVR  = 1;  // overrun
    localparam int RING_W    = 2;

    typedef logic [SRC_W-1:0] strm_src_t;
endpackage

// File: rtl/aud_irq_ctrl_src.sv
// Controller cause: combines qualified ring flags with codec state-change flags.
// Assumes all inputs are level flags held by their owners until cleared.
module aud_irq_ctrl_src
    import aud_irq_pkg::*;
#(
    parameter int NUM_CODECS = 15
)(
    input  logic [RING_W-1:0]     ring_sts,
    input  logic [RING_W-1:0]     ring_ctl,
    input  logic [NUM_CODECS-1:0] codec_sts,
    input  logic [NUM_CODECS-1:0] wake_en,
    output logic                  ctrl_cause
);
    logic ring_hit;
    logic codec_hit;
    logic wake_hit;

    // Qualify each source group and merge them into one controller cause.
    always_comb begin
        ring_hit   = ring_sts[RING_RESP] & ring_ctl[RING_RESP]
                   | ring_sts[RING_OVR]  & ring_ctl[RING_OVR];
        codec_hit  = |codec_sts;
        wake_hit   = |(codec_sts & wake_en);
        ctrl_cause = ring_hit | codec_hit | wake_hit;
    end
endmodule

// File: rtl/aud_irq_strm_src.sv
// Stream causes: one bit per stream, set when any enabled status bit is set.
// Assumes status and control fields use the package bit layout.
module aud_irq_strm_src
    import aud_irq_pkg::*;
#(
    parameter int NUM_STREAMS = 8
)(
    input  logic [NUM_STREAMS-1:0][SRC_W-1:0] strm_sts,
    input  logic [NUM_STREAMS-1:0][SRC_W-1:0] strm_ctl,
    output logic [NUM_STREAMS-1:0]            strm_cause
);
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_strm
        strm_src_t hit;
        // Qualify this stream's status with its own enables.
        always_comb begin
            hit = strm_sts[s] & strm_ctl[s];
            strm_cause[s] = hit[SRC_IOC] | hit[SRC_FIFO] | hit[SRC_DESC];
        end
    end
endmodule

// File: rtl/aud_irq_line_gate.sv
// Line gate: decides the next interrupt level from the next status word.
// Assumes the global bit position is excluded from the enable mask.
module aud_irq_line_gate #(
    parameter int STS_W       = 32,
    parameter int NUM_STREAMS = 8,
    parameter int CTRL_BIT    = 30,
    parameter int GLOB_BIT    = 31
)(
    input  logic [STS_W-1:0] sts_next,
    input  logic [STS_W-1:0] int_ctl,
    output logic             irq_next
);
    localparam logic [STS_W-1:0] STRM_MASK = STS_W'((64'd1 << NUM_STREAMS) - 64'd1);
    localparam logic [STS_W-1:0] CTRL_MASK = STS_W'(64'd1 << CTRL_BIT);
    localparam logic [STS_W-1:0] EN_MASK   = STRM_MASK | CTRL_MASK;

    // Raise only with master enable and an individually enabled cause.
    always_comb begin
        irq_next = int_ctl[GLOB_BIT] & (|(sts_next & int_ctl & EN_MASK));
    end
endmodule

// File: rtl/aud_irq_aggr.sv
// Interrupt aggregator top: builds the status word each cycle and registers
// it with the interrupt line. Assumes NUM_STREAMS <= CTRL_BIT < GLOB_BIT < STS_W.
module aud_irq_aggr
    import aud_irq_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int NUM_CODECS  = 15,
    parameter int STS_W       = 32,
    parameter int CTRL_BIT    = 30,
    parameter int GLOB_BIT    = 31
)(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [RING_W-1:0]                 ring_sts,
    input  logic [RING_W-1:0]                 ring_ctl,
    input  logic [NUM_CODECS-1:0]             codec_sts,
    input  logic [NUM_CODECS-1:0]             wake_en,
    input  logic [NUM_STREAMS-1:0][SRC_W-1:0] strm_sts,
    input  logic [NUM_STREAMS-1:0][SRC_W-1:0] strm_ctl,
    input  logic [STS_W-1:0]                  int_ctl,
    output logic [STS_W-1:0]                  int_sts,
    output logic                              irq
);
    localparam int RSV_LO = NUM_STREAMS;
    localparam int RSV_HI = CTRL_BIT - 1;

    logic                   ctrl_cause;
    logic [NUM_STREAMS-1:0] strm_cause;
    logic [STS_W-1:0]       sts_next;
    logic                   irq_next;

    aud_irq_ctrl_src #(.NUM_CODECS(NUM_CODECS)) u_ctrl (
        .ring_sts   (ring_sts),
        .ring_ctl   (ring_ctl),
        .codec_sts  (codec_sts),
        .wake_en    (wake_en),
        .ctrl_cause (ctrl_cause)
    );

    aud_irq_strm_src #(.NUM_STREAMS(NUM_STREAMS)) u_strm (
        .strm_sts   (strm_sts),
        .strm_ctl   (strm_ctl),
        .strm_cause (strm_cause)
    );

    // Assemble the next status word; global bit summarises all others.
    always_comb begin
        sts_next                    = '0;
        sts_next[NUM_STREAMS-1:0]   = strm_cause;
        sts_next[CTRL_BIT]          = ctrl_cause;
        sts_next[GLOB_BIT]          = ctrl_cause | (|strm_cause);
    end

    aud_irq_line_gate #(
        .STS_W       (STS_W),
        .NUM_STREAMS (NUM_STREAMS),
        .CTRL_BIT    (CTRL_BIT),
        .GLOB_BIT    (GLOB_BIT)
    ) u_gate (
        .sts_next (sts_next),
        .int_ctl  (int_ctl),
        .irq_next (irq_next)
    );

    // Register status word and line; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_sts <= '0;
            irq     <= 1'b0;
        end else begin
            int_sts <= sts_next;
            irq     <= irq_next;
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (int_sts == '0) && !irq);

    // R5
    glob_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_sts[GLOB_BIT] == (|int_sts[GLOB_BIT-1:0]));

    // R5
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_sts[RSV_HI:RSV_LO] == '0);

    // R6
    irq_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && irq |-> $past(int_ctl[GLOB_BIT]));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && irq |->
            (|(int_sts[NUM_STREAMS-1:0] & $past(int_ctl[NUM_STREAMS-1:0])))
            || (int_sts[CTRL_BIT] && $past(int_ctl[CTRL_BIT])));

    // R2
    ring_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(|(ring_sts & ring_ctl)) |-> int_sts[CTRL_BIT]);

    // R3
    codec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(|codec_sts) |-> int_sts[CTRL_BIT]);

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_chk
        // R4, R8
        strm_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> int_sts[s] == $past(|(strm_sts[s] & strm_ctl[s])));
    end
endmodule

// File: tb/aud_irq_aggr_tb.sv
module aud_irq_aggr_tb;
    import aud_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NC = 15;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [RING_W-1:0]        ring_sts, ring_ctl;
    logic [NC-1:0]            codec_sts, wake_en;
    logic [NS-1:0][SRC_W-1:0] strm_sts, strm_ctl;
    logic [31:0]              int_ctl;
    logic [31:0]              int_sts;
    logic                     irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    aud_irq_aggr u_dut (
        .clk(clk), .rst_n(rst_n),
        .ring_sts(ring_sts), .ring_ctl(ring_ctl),
        .codec_sts(codec_sts), .wake_en(wake_en),
        .strm_sts(strm_sts), .strm_ctl(strm_ctl),
        .int_ctl(int_ctl), .int_sts(int_sts), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [31:0] exp_s, input logic exp_i, input string tag);
        n_chk++;
        if (int_sts !== exp_s || irq !== exp_i) begin
            n_fail++;
            $display("FAIL %s: int_sts=%h irq=%b expected int_sts=%h irq=%b",
                     tag, int_sts, irq, exp_s, exp_i);
        end
    endtask

    task automatic clear_inputs();
        ring_sts = '0; ring_ctl = '0; codec_sts = '0; wake_en = '0;
        strm_sts = '0; strm_ctl = '0; int_ctl = '0;
    endtask

    // Apply inputs at the falling edge, sample just after the next rising edge.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ring_sts = 2'b11; ring_ctl = 2'b11; int_ctl = 32'hFFFF_FFFF;
        step();
        chk(32'h0, 1'b0, "R1 reset clears");
        @(negedge clk); clear_inputs(); rst_n = 1'b1;
        step();
        chk(32'h0, 1'b0, "R1 idle after reset");
    endtask

    task automatic t_ring();
        @(negedge clk); clear_inputs();
        ring_sts = 2'b01; ring_ctl = 2'b10; int_ctl = 32'hC000_0000;
        step();
        chk(32'h0, 1'b0, "R2 unmatched ring enable");
        @(negedge clk); ring_ctl = 2'b01;
        step();
        chk(32'hC000_0000, 1'b1, "R2 response path");
        @(negedge clk); ring_sts = 2'b10; ring_ctl = 2'b10;
        step();
        chk(32'hC000_0000, 1'b1, "R2 overrun path");
    endtask

    task automatic t_codec();
        @(negedge clk); clear_inputs();
        codec_sts = 15'h0004; int_ctl = 32'h8000_0000;
        step();
        chk(32'hC000_0000, 1'b0, "R3/R7 codec flag, only master enabled");
        @(negedge clk); wake_en = 15'h0004; int_ctl = 32'hC000_0000;
        step();
        chk(32'hC000_0000, 1'b1, "R3 codec with wake mask");
    endtask

    task automatic t_stream();
        @(negedge clk); clear_inputs();
        strm_sts[3] = 3'b001; strm_ctl[3] = 3'b001; int_ctl = 32'h8000_0008;
        step();
        chk(32'h8000_0008, 1'b1, "R4 stream 3 completion");
        @(negedge clk); int_ctl = 32'h8000_0004;
        step();
        chk(32'h8000_0008, 1'b0, "R6 stream enable mismatch");
        @(negedge clk); clear_inputs();
        strm_sts[7] = 3'b010; strm_ctl[7] = 3'b010;
        strm_sts[0] = 3'b100; strm_ctl[0] = 3'b100;
        strm_sts[5] = 3'b100; strm_ctl[5] = 3'b011;
        int_ctl = 32'h8000_0001;
        step();
        chk(32'h8000_0081, 1'b1, "R4 FIFO and descriptor errors, masked stream 5");
    endtask

    task automatic t_master();
        @(negedge clk); clear_inputs();
        for (int s = 0; s < NS; s++) begin
            strm_sts[s] = 3'b111; strm_ctl[s] = 3'b111;
        end
        ring_sts = 2'b11; ring_ctl = 2'b11;
        int_ctl = 32'h7FFF_FFFF;
        step();
        chk(32'hC000_00FF, 1'b0, "R5/R6 all causes, master off");
        @(negedge clk); int_ctl = 32'hFFFF_FFFF;
        step();
        chk(32'hC000_00FF, 1'b1, "R6 all causes, master on");
    endtask

    task automatic t_latency();
        @(negedge clk); clear_inputs();
        step();
        @(negedge clk);
        strm_sts[2] = 3'b001; strm_ctl[2] = 3'b001; int_ctl = 32'h8000_0004;
        #1;
        chk(32'h0, 1'b0, "R8 no change before edge");
        step();
        chk(32'h8000_0004, 1'b1, "R8 change after edge");
        @(negedge clk); clear_inputs();
        step();
        chk(32'h0, 1'b0, "R8 release after edge");
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        clear_inputs();
        repeat (2) @(posedge clk);
        t_reset();
        t_ring();
        t_codec();
        t_stream();
        t_master();
        t_latency();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule